// File: doc/BRIEF.md
# Cross-Domain Time Counter Snapshot

This block keeps a free-running nanosecond time counter in a timestamp clock domain and lets software in a separate register-bus clock domain read it or zero it safely. Software writes a control word with a capture bit, a restart bit, or both. The request is carried into the counter domain, where the counter is latched or cleared. An acknowledge then returns to the bus domain.

The request bits stay set while the operation is in flight and clear only once it has fully completed. Software therefore sets capture, polls the control register until the bit reads 0, and then reads the value register. The multi-bit snapshot is loaded into the bus-side value register only after the acknowledge has crossed back. A bus read can never see a value that is partly updated.

The counter adds a fixed increment on every timestamp clock and wraps at one second. A full round trip takes at most six cycles of whichever clock is slower.

Top module: `ts_snap_top`

## Requirements
- R1: After reset the control register (address 0) and the value register (address 1) both read 0.
- R2: Writing address 0 with bit 0 (capture) set makes bit 0 read 1 from the next cycle until the snapshot has reached the value register, then it clears by itself.
- R3: Capture and restart bits clear no later than 6 cycles of the slower of the two clocks after the write.
- R4: While an operation is pending, the value register keeps its previous contents; it changes only when the operation completes.
- R5: Successive captures without an intervening restart return strictly increasing values, each a multiple of the per-cycle increment (40 ns by default).
- R6: Writing address 0 with bit 1 (restart) set makes bit 1 read 1 until the counter has been zeroed, then it clears; later captures count up from 0.
- R7: Writing capture and restart together (value 3) zeroes the counter first, and the captured value is 0.
- R8: A control write while any operation is pending is ignored entirely: no second request is issued and neither bit changes.
- R9: The counter stays below the wrap limit (10^9 ns by default) and wraps to 0 on reaching it.
- R10: A restart without capture leaves the value register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk_i | input | 1 | Register-bus clock |
| ts_clk_i | input | 1 | Timestamp counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| bus_we_i | input | 1 | Write strobe, register clock domain |
| bus_addr_i | input | 1 | Register select: 0 control, 1 value |
| bus_wdata_i | input | CNT_W | Write data; bit 0 capture, bit 1 restart |
| bus_rdata_o | output | CNT_W | Read data for the selected register |

## Verification
A request toggle that is lost or doubled shows at the control register as a bit that never clears, or that clears without the value changing. This becomes visible within the six-slow-cycle window. A snapshot taken at the wrong moment, or copied early, shows as a value that changes while the bit still reads 1, a non-monotonic sequence, or a nonzero result for a combined restart and capture. A bad wrap shows on a small-wrap instance as a value at or above the limit within a few captures.

// File: rtl/ts_snap_pkg.sv
package ts_snap_pkg;
  localparam logic CTRL_ADDR = 1'b0;
  localparam logic VAL_ADDR  = 1'b1;
  localparam int   CAP_BIT   = 0;
  localparam int   RST_BIT   = 1;

  typedef struct packed {
    logic rst;
    logic cap;
  } snap_op_t;
endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ts_cnt_core.sv
module ts_cnt_core
  import ts_snap_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int unsigned INC_NS  = 40,
  parameter int unsigned WRAP_NS = 1000000000,
  parameter int          STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  input  snap_op_t         op_i,
  output logic             ack_tgl_o,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W:0]   INC_X  = (CNT_W+1)'(INC_NS);
  localparam logic [CNT_W:0]   WRAP_X = (CNT_W+1)'(WRAP_NS);
  localparam logic [CNT_W-1:0] INC_V  = CNT_W'(INC_NS);

  logic             req_s, req_seen_q, act;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   sum;

  ts_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s)
  );

  assign act = req_s ^ req_seen_q;
  assign sum = {1'b0, cnt_q} + INC_X;
  assign cnt_nxt = (sum >= WRAP_X) ? CNT_W'(sum - WRAP_X) : sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      snap_o     <= '0;
      req_seen_q <= 1'b0;
      ack_tgl_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (act) begin
        req_seen_q <= req_s;
        ack_tgl_o  <= ~ack_tgl_o;
        if (op_i.rst) cnt_q  <= '0;
        // restart wins over a simultaneous capture
        if (op_i.cap) snap_o <= op_i.rst ? '0 : cnt_q;
      end
    end
  end

  // R6
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && op_i.rst) |=> (cnt_q == '0));

  // R9
  wrap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < WRAP_X) && ((cnt_q % INC_V) == '0));

  // R7
  both_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && op_i.rst && op_i.cap) |=> (snap_o == '0));
endmodule

// File: rtl/ts_reg_side.sv
module ts_reg_side
  import ts_snap_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int STAGES   = 2,
  parameter int MAX_WAIT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output snap_op_t         op_o,
  output logic             req_tgl_o,
  input  logic             ack_tgl_i,
  input  logic [CNT_W-1:0] snap_i
);
  localparam int WAIT_W = $clog2(MAX_WAIT + 2);

  logic             ack_s, ack_seen_q, ack_edge, pending, issue;
  logic [CNT_W-1:0] val_q;

  ts_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_tgl_i), .q_o(ack_s)
  );

  assign ack_edge = ack_s ^ ack_seen_q;
  assign pending  = op_o.cap | op_o.rst;
  assign issue    = we_i && (addr_i == CTRL_ADDR) && !pending
                    && (wdata_i[CAP_BIT] || wdata_i[RST_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o       <= '0;
      req_tgl_o  <= 1'b0;
      ack_seen_q <= 1'b0;
      val_q      <= '0;
    end else begin
      if (issue) begin
        // op bits stay static while the toggle crosses
        op_o.cap  <= wdata_i[CAP_BIT];
        op_o.rst  <= wdata_i[RST_BIT];
        req_tgl_o <= ~req_tgl_o;
      end else if (ack_edge) begin
        ack_seen_q <= ack_s;
        op_o       <= '0;
        if (op_o.cap) val_q <= snap_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == VAL_ADDR) rdata_o = val_q;
    else begin
      rdata_o[CAP_BIT] = op_o.cap;
      rdata_o[RST_BIT] = op_o.rst;
    end
  end

  logic [WAIT_W-1:0] wait_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   wait_q <= '0;
    else if (!pending)             wait_q <= '0;
    else if (wait_q != '1)         wait_q <= wait_q + 1'b1;
  end

  // R2
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o.cap && !ack_edge) |=> op_o.cap);

  // R3
  wait_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q <= WAIT_W'(MAX_WAIT));

  // R4
  val_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(val_q) |-> ($past(op_o.cap) && !op_o.cap));

  // R8
  no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |=> $stable(req_tgl_o));
endmodule

// File: rtl/ts_snap_top.sv
module ts_snap_top
  import ts_snap_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int unsigned INC_NS   = 40,
  parameter int unsigned WRAP_NS  = 1000000000,
  parameter int          STAGES   = 2,
  parameter int          MAX_WAIT = 32
) (
  input  logic             reg_clk_i,
  input  logic             ts_clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o
);
  snap_op_t         op;
  logic             req_tgl, ack_tgl;
  logic [CNT_W-1:0] snap;

  ts_reg_side #(.CNT_W(CNT_W), .STAGES(STAGES), .MAX_WAIT(MAX_WAIT)) u_reg (
    .clk_i(reg_clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .op_o(op),
    .req_tgl_o(req_tgl), .ack_tgl_i(ack_tgl), .snap_i(snap)
  );

  ts_cnt_core #(.CNT_W(CNT_W), .INC_NS(INC_NS), .WRAP_NS(WRAP_NS), .STAGES(STAGES)) u_core (
    .clk_i(ts_clk_i), .rst_ni(rst_ni), .req_tgl_i(req_tgl), .op_i(op),
    .ack_tgl_o(ack_tgl), .snap_o(snap)
  );
endmodule

// File: tb/tb_ts_snap_top.sv
module tb_ts_snap_top;
  localparam int MAXW = 30; // 6 x 40 ns slow clock / 8 ns bus clock

  logic        reg_clk = 0, ts_clk = 0, rst_n = 0;
  logic        we = 0, addr = 0;
  logic [31:0] wdata = '0, rdata, rdata_w;
  int checks = 0, errors = 0;
  longint ts_cnt = 0;

  always #4  reg_clk = ~reg_clk;
  always #20 ts_clk  = ~ts_clk;
  always @(posedge ts_clk) ts_cnt++;

  ts_snap_top dut (
    .reg_clk_i(reg_clk), .ts_clk_i(ts_clk), .rst_ni(rst_n), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );
  ts_snap_top #(.WRAP_NS(400)) dut_w (
    .reg_clk_i(reg_clk), .ts_clk_i(ts_clk), .rst_ni(rst_n), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_w)
  );

  // {op[1:0] = {restart,capture}, gap[7:0]}
  localparam logic [9:0] VEC [10] = '{
    {2'b01, 8'd5},  {2'b01, 8'd20}, {2'b01, 8'd0},  {2'b10, 8'd3},
    {2'b01, 8'd10}, {2'b11, 8'd4},  {2'b01, 8'd50}, {2'b10, 8'd1},
    {2'b01, 8'd0},  {2'b01, 8'd7}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge reg_clk);
    we = 1; addr = a; wdata = d;
    @(negedge reg_clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v, output logic [31:0] vw);
    addr = a; #1; v = rdata; vw = rdata_w;
  endtask

  // polls until idle; returns cycles and flags a value change while busy
  task automatic wait_idle(input logic [31:0] prev, output int n, output logic moved);
    logic [31:0] c, cw, v, vw;
    n = 0; moved = 0;
    for (int i = 0; i < 200; i++) begin
      rd(1'b0, c, cw);
      if (c[1:0] == 2'b00 && cw[1:0] == 2'b00) break;
      rd(1'b1, v, vw);
      if (v != prev) moved = 1;
      n++;
      @(negedge reg_clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c, cw, v, vw, prev, last_cap;
    logic restarted, moved;
    longint mark;
    int n;
    last_cap = 0; restarted = 0; mark = 0;

    // R1 reset state
    #3;
    rd(1'b0, c, cw);
    chk(c == 0, "R1 ctrl in reset", c, 0);
    rd(1'b1, v, vw);
    chk(v == 0, "R1 value in reset", v, 0);
    repeat (3) @(negedge reg_clk);
    rst_n = 1;
    repeat (2) @(negedge reg_clk);
    rd(1'b0, c, cw);
    chk(c == 0, "R1 ctrl after reset", c, 0);
    rd(1'b1, v, vw);
    chk(v == 0, "R1 value after reset", v, 0);

    for (int k = 0; k < 10; k++) begin
      logic [1:0] op;
      op = VEC[k][9:8];
      repeat (VEC[k][7:0]) @(negedge reg_clk);
      rd(1'b1, prev, vw);
      if (op[1]) mark = ts_cnt;
      wr(1'b0, {30'd0, op});
      rd(1'b0, c, cw);
      chk(c[1:0] == op, op[1] ? "R6 restart bit set" : "R2 capture bit set", c[1:0], op);
      wait_idle(prev, n, moved);
      chk(n <= MAXW, "R3 completion window", n, MAXW);
      chk(!moved, "R4 value held while pending", moved, 0);
      rd(1'b1, v, vw);
      if (op == 2'b11) begin
        chk(v == 0, "R7 restart+capture yields 0", v, 0);
        last_cap = 0; restarted = 0;
      end else if (op == 2'b10) begin
        chk(v == prev, "R10 restart keeps value", v, prev);
        restarted = 1;
      end else begin
        if (restarted)
          chk(v <= 40 * (ts_cnt - mark + 2), "R6 count from zero", v, 40 * (ts_cnt - mark + 2));
        else
          chk(v > last_cap, "R5 monotonic capture", v, last_cap);
        chk(v % 40 == 0, "R5 increment multiple", v % 40, 0);
        chk(vw < 400 && vw % 40 == 0, "R9 wrap bound", vw, 400);
        last_cap = v; restarted = 0;
      end
    end

    // R8 second write during a pending capture is ignored
    rd(1'b1, prev, vw);
    wr(1'b0, 32'd1);
    wr(1'b0, 32'd3);
    rd(1'b0, c, cw);
    chk(c[1:0] == 2'b01, "R8 restart ignored while pending", c[1:0], 1);
    wait_idle(prev, n, moved);
    rd(1'b1, v, vw);
    chk(v > last_cap, "R8 no restart took effect", v, last_cap);
    last_cap = v;
    repeat (40) @(negedge reg_clk);
    rd(1'b1, prev, vw);
    wr(1'b0, 32'd1);
    wait_idle(prev, n, moved);
    rd(1'b1, v, vw);
    chk(v > last_cap, "R5 capture after ignored write", v, last_cap);
    rd(1'b0, c, cw);
    chk(c == 0, "R2 capture bit cleared", c, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule